// File: doc/BRIEF.md
# Reconfigurable-Bus Column Ranker

The block assigns each flagged column of an N-column row its position among the flagged columns, counting from column 0. It does this without an adder tree. Instead it models an N×N grid of switch nodes. Each node has an east link and a south link, and each link is set from the node's copy of a flag bit and from the parity of the node's row and column. A marker starts at the top-left node and travels through the closed links. The marker bus steps down two rows for every flagged column it crosses, so the row at which it enters a column gives the count of flagged columns to its left.

Even and odd columns are counted in two separate grids. The odd grid is the even grid shifted by one column. Each column's inclusive count from its own parity class is added to the inclusive count of the neighbour on its left, which belongs to the other class, and one is subtracted.

A one-cycle start pulse snapshots the flag vector. Three clock edges later the rank vector is updated and a one-cycle valid pulse is raised. The ranks then hold until the next result.

Top module: `rank_bus_grid`

## Requirements
- R1: While reset is asserted (rst_n low) and after it, until the first result, valid_o is 0 and every rank field reads 0.
- R2: A start_i sampled high at a clock edge produces valid_o high for exactly the cycle after the third clock edge counted from that edge. valid_o is never high otherwise.
- R3: When valid_o is high, the field rank_o[j*RW +: RW] of every column j whose flag sel_i[j] was 1 at the start edge equals the number of flagged columns with an index below j. Column 0 is bit 0 of sel_i.
- R4: For the flag pattern where columns 1, 2, 5, 6, 7, 9, 10, 11, 12 and 14 are flagged (N=16), those columns receive ranks 0 through 9 in ascending column order.
- R5: With every column flagged, column j receives rank j.
- R6: With a single column flagged, that column receives rank 0, wherever it lies (the first column and the last column included).
- R7: Changes on sel_i at edges where start_i is low have no effect on the result produced by an earlier start.
- R8: rank_o changes only at the edge that raises valid_o, and holds its value between results.
- R9: Starts on consecutive cycles each produce their own result, on consecutive cycles and in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request; snapshots sel_i |
| sel_i | input | N | Flag per column, bit j for column j |
| rank_o | output | N*RW | Rank of column j in bits [j*RW +: RW]; meaningless for unflagged columns |
| valid_o | output | 1 | One-cycle pulse marking a fresh rank vector |

## Verification
The mixed pattern from R4 sends the marker down staircases in both parity grids and tests how the two partial counts are combined. All-flagged drives the marker to the grid's deepest rows. Single-flag patterns at column 0, at column N-1 and at an odd middle column separate a wrong start corner from a wrong boundary column and from a wrong offset in the odd grid. Alternating patterns leave one parity grid flat while the other descends, and the hold and back-to-back scenarios check that the snapshot is taken at the start edge and that results stay in order.

// File: rtl/rank_bus_grid.sv
module rank_bus_grid #(
  parameter int N  = 16,
  parameter int RW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [N-1:0]    sel_i,
  output logic [N*RW-1:0] rank_o,
  output logic            valid_o
);
  localparam int CW = $clog2(N) + 1;
  localparam int HP = N / 2;

  logic [N-1:0]  sel_q;
  logic          p1, p2;
  logic [CW-1:0] rinc [N];
  logic [CW-1:0] r_q  [N];
  logic [RW-1:0] rank_d [N];

  function automatic logic [CW-1:0] depth_count(input logic [N-1:0] col, input logic flag);
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i += 2)
      if (col[i]) acc = acc | CW'(i / 2 + int'(flag));
    return acc;
  endfunction

  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [N-1:0] flag;
    logic [N-1:0] hitv [N];

    for (genvar k = 0; k < N; k++) begin : g_flag
      assign flag[k] = sel_q[(k / 2) * 2 + c];
    end

    for (genvar i = 0; i < N; i++) begin : g_r
      for (genvar k = 0; k < N; k++) begin : g_c
        logic e_sw, s_sw, hit, from_w, from_n;
        assign e_sw = flag[k] ? ((i % 2) != (k % 2)) : ((i % 2) == 0);
        assign s_sw = flag[k] ? ((i % 2) == (k % 2)) : 1'b0;
        if (k == 0) begin : g_w0
          assign from_w = (i == 0);
        end else begin : g_w1
          assign from_w = g_r[i].g_c[k-1].hit & g_r[i].g_c[k-1].e_sw;
        end
        if (i == 0) begin : g_n0
          assign from_n = 1'b0;
        end else begin : g_n1
          assign from_n = g_r[i-1].g_c[k].hit & g_r[i-1].g_c[k].s_sw;
        end
        assign hit = from_w | from_n;
        assign hitv[k][i] = hit;
      end
    end

    for (genvar p = 0; p < HP; p++) begin : g_lead
      assign rinc[2*p + c] = depth_count(hitv[2*p], flag[2*p]);
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_comb
    logic [CW:0] sum;
    if (j == 0) begin : g_first
      assign sum = {1'b0, r_q[0]} - 1'b1;
    end else begin : g_rest
      assign sum = {1'b0, r_q[j]} + {1'b0, r_q[j-1]} - 1'b1;
    end
    assign rank_d[j] = sum[RW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      p1      <= 1'b0;
      p2      <= 1'b0;
      valid_o <= 1'b0;
      rank_o  <= '0;
      for (int j = 0; j < N; j++) r_q[j] <= '0;
    end else begin
      p1      <= start_i;
      p2      <= p1;
      valid_o <= p2;
      if (start_i) sel_q <= sel_i;
      if (p1) for (int j = 0; j < N; j++) r_q[j] <= rinc[j];
      if (p2) for (int j = 0; j < N; j++) rank_o[j*RW +: RW] <= rank_d[j];
    end
  end
endmodule

// File: rtl/rank_bus_grid_chk.sv
module rank_bus_grid_chk #(
  parameter int N  = 16,
  parameter int RW = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [N-1:0]    sel_i,
  input logic [N*RW-1:0] rank_o,
  input logic            valid_o
);
  logic [N-1:0] c0, c1, c2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0 <= '0; c1 <= '0; c2 <= '0;
    end else begin
      if (start_i) c0 <= sel_i;
      c1 <= c0;
      c2 <= c1;
    end
  end

  function automatic int below(input logic [N-1:0] v, input int j);
    int n;
    n = 0;
    for (int q = 0; q < N; q++) if (q < j && v[q]) n++;
    return n;
  endfunction

  // R2
  start_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) start_i |-> ##3 valid_o);
  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> $past(start_i, 3));
  // R8
  rank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> $stable(rank_o));

  for (genvar j = 0; j < N; j++) begin : g_rk
    // R3
    rank_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && c2[j]) |-> rank_o[j*RW +: RW] == RW'(below(c2, j)));
  end
endmodule

bind rank_bus_grid rank_bus_grid_chk #(.N(N), .RW(RW)) u_chk (.*);

// File: tb/test_rank_bus_grid.sv
`timescale 1ns/1ps
module test_rank_bus_grid;
  localparam int N  = 16;
  localparam int RW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [N-1:0] sel_i = '0;
  logic [N*RW-1:0] rank_o;
  logic valid_o;
  int checks = 0, fails = 0;

  rank_bus_grid #(.N(N), .RW(RW)) i_rank_bus_grid (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
    .rank_o(rank_o), .valid_o(valid_o));

  always #4 clk = ~clk;

  function automatic int below(input logic [N-1:0] v, input int j);
    int n = 0;
    for (int q = 0; q < j; q++) if (v[q]) n++;
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_ranks(input string req, input logic [N-1:0] p);
    for (int j = 0; j < N; j++)
      if (p[j]) check(req, int'(rank_o[j*RW +: RW]), below(p, j));
  endtask

  task automatic run(input string req, input logic [N-1:0] p);
    @(negedge clk); sel_i = p; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check({"R2 ", req}, int'(valid_o), 0);
    @(negedge clk); check({"R2 ", req}, int'(valid_o), 0);
    @(negedge clk); check({"R2 ", req}, int'(valid_o), 1);
    check_ranks(req, p);
    @(negedge clk); check({"R2 ", req}, int'(valid_o), 0);
  endtask

  task automatic t_reset;
    check("R1 valid", int'(valid_o), 0);
    check("R1 ranks", int'(rank_o != '0), 0);
  endtask

  task automatic t_example;
    logic [N-1:0] p = 16'b0101_1110_1110_0110;
    int want = 0;
    run("R4", p);
    for (int j = 0; j < N; j++)
      if (p[j]) begin check("R4", int'(rank_o[j*RW +: RW]), want); want++; end
  endtask

  task automatic t_all;
    run("R5", '1);
    for (int j = 0; j < N; j++) check("R5", int'(rank_o[j*RW +: RW]), j);
  endtask

  task automatic t_single;
    run("R6", N'(1));
    run("R6", N'(1) << (N-1));
    run("R6", N'(1) << 5);
  endtask

  task automatic t_mixed;
    run("R3 alt-even", {(N/2){2'b01}});
    run("R3 alt-odd",  {(N/2){2'b10}});
    run("R3 pairs",    {(N/4){4'b1100}});
    run("R3 none",     '0);
  endtask

  task automatic t_hold;
    logic [N-1:0] p = 16'h9a53;
    logic [N*RW-1:0] snap;
    run("R3 hold-base", p);
    snap = rank_o;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); sel_i = ~sel_i ^ N'(k * 37);
      check("R8 no valid", int'(valid_o), 0);
      check("R7 ranks kept", int'(rank_o == snap), 1);
    end
  endtask

  task automatic t_b2b;
    logic [N-1:0] a = 16'hf00f, b = 16'h0ff0;
    @(negedge clk); sel_i = a; start_i = 1'b1;
    @(negedge clk); sel_i = b;
    @(negedge clk); start_i = 1'b0; sel_i = '0;
    @(negedge clk); check("R9 first valid", int'(valid_o), 1);
    check_ranks("R9 first", a);
    @(negedge clk); check("R9 second valid", int'(valid_o), 1);
    check_ranks("R9 second", b);
    @(negedge clk); check("R9 end", int'(valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_all();
    t_single();
    t_mixed();
    t_hold();
    t_b2b();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule